// File: doc/BRIEF.md
# Receive Ring Frame Writer

This block takes received Ethernet frames as a byte stream and stores each one as a self-describing record in a circular receive area of a 16-bit wide local packet memory. A record is a four-word header followed by the payload. The header words are a completion event, a status word, a link to the next record and a byte count. The payload bytes are packed two to a word, with the earlier byte in the low half. The receive area runs from a lower page to an upper page, where a page is 256 bytes. Writing wraps from the top word of the upper page back to the start of the lower page. The block drives a simple synchronous RAM write port: a word address, write data and a write enable.

The host reads records starting at the current write base. It hands consumed storage back by writing a stop address. The writer never touches the memory word that holds the stop address. A frame that does not fit is discarded. The block then pulses an overrun flag and leaves the write base where it was, so the next frame starts in the same place.

The completion event is the last header word to be written. The writer then clears the event word of the following record. The host therefore never sees a record as complete while its other words are still being written.

Top module: `rx_ring_writer`

## Requirements
- R1: During and just after reset, `wr_base` equals the lower page times 256, and `overrun` and `frame_done` are low. `in_ready` stays low until the block's first memory write, which stores 0x0000 at the word `wr_base`. After that write, `in_ready` goes high.
- R2: A stored record at byte address B holds the event word at B, the status word at B+2, the next-record address at B+4 and the byte count at B+6, with each step wrapped as R7 describes. The payload follows the count word. Byte 2k is the low half and byte 2k+1 is the high half of payload word k. When the frame has an odd length, its last word carries 0x00 in the high half.
- R3: The event word 0x0008 is written to B in the same cycle that `frame_done` rises. All other record words are written before it. Until then, the word at B holds 0x0000.
- R4: The status word is 0x2000 for a good frame. It is 0x0001 when `in_err` was high on any accepted byte of the frame. A host treats a record as good when the status masked with 0x0D81|0x2000 equals 0x2000.
- R5: The count word holds the frame's byte count in bits 13:0. Bits 15:14 are zero.
- R6: The next-record field holds the byte address of the word that follows the last payload word, wrapped as R7 describes. `wr_base` takes this value in the cycle that `frame_done` is high, and changes at no other time.
- R7: The word that follows byte address (upper page × 256) + 0xFE is lower page × 256. Every memory write lies inside the receive area.
- R8: The stop address resets to (upper page × 256) + 0xFE. While `stop_we` is high, the next clock loads it from `stop_wdata`.
- R9: The writer never writes the word that holds the stop address, apart from clearing the next record's event word (R11). A frame is dropped when fewer than four words lie between `wr_base` and the stop word, or when one of its payload words would land on the stop word. A dropped frame pulses `overrun` for one cycle, does not raise `frame_done`, and has its remaining bytes accepted and discarded. `wr_base` and the word at it stay unchanged.
- R10: After the last byte of a stored frame is accepted, `in_ready` is low for exactly 5 cycles. It is high while the block is waiting for a frame, receiving a frame or discarding a frame.
- R11: In the cycle after `frame_done`, the block writes 0x0000 to the event word at the new `wr_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A byte is offered |
| in_byte | input | 8 | Frame byte |
| in_last | input | 1 | Offered byte ends the frame |
| in_err | input | 1 | Frame has an error (any byte) |
| in_ready | output | 1 | Offered byte is taken this cycle |
| lim_lo | input | AW-8 | First page of the receive area |
| lim_hi | input | AW-8 | Last page of the receive area |
| stop_we | input | 1 | Load the stop address |
| stop_wdata | input | AW | New stop byte address |
| mem_we | output | 1 | Memory write enable |
| mem_waddr | output | AW-1 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| wr_base | output | AW | Byte address of the record being written next |
| frame_done | output | 1 | One-cycle pulse when a record is complete |
| overrun | output | 1 | One-cycle pulse when a frame is dropped |

## Verification
The bench builds the block with AW = 11, so the memory is 1024 words, and uses pages 1 to 3 as a 384-word ring. That ring is small enough that a sweep of frame lengths 1 to 40 wraps records across the top page several times. The same small ring lets a single 758-byte frame fill it exactly from reset, while 759 bytes overrun it, which pins down the stop address's reset value. Stop addresses set 2, 4 and 5 words ahead of the base cover the header-space and first-payload-word boundaries one by one.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  localparam logic [15:0] EVT_DONE = 16'h0008;
  localparam logic [15:0] EVT_PEND = 16'h0000;
  localparam logic [15:0] ST_GOOD  = 16'h2000;
  localparam logic [15:0] ST_BAD   = 16'h0001;
  localparam int HDR_WORDS = 4;
  localparam int CNT_BITS  = 14;
  localparam int PAGE_LOG  = 7;   // words per 256-byte page, log2

  typedef enum logic [2:0] {
    S_CLR, S_IDLE, S_RECV, S_DROP, S_HST, S_HNX, S_HCT, S_HEV
  } wr_state_t;

  // word index that follows w inside the ring [first_w, last_w]
  function automatic logic [15:0] ring_step(input logic [15:0] w,
                                            input logic [15:0] first_w,
                                            input logic [15:0] last_w);
    return (w == last_w) ? first_w : w + 16'd1;
  endfunction

  // number of forward steps from from_w to to_w inside the ring
  function automatic logic [15:0] ring_gap(input logic [15:0] from_w,
                                           input logic [15:0] to_w,
                                           input logic [15:0] first_w,
                                           input logic [15:0] last_w);
    if (to_w >= from_w) return to_w - from_w;
    return to_w + (last_w - first_w + 16'd1) - from_w;
  endfunction

endpackage

// File: rtl/rxr_step.sv
module rxr_step #(
  parameter int WW = 14
) (
  input  logic [WW-1:0] cur_i,
  input  logic [WW-1:0] first_i,
  input  logic [WW-1:0] last_i,
  output logic [WW-1:0] nxt_o
);
  import rxr_pkg::*;

  assign nxt_o = WW'(ring_step(16'(cur_i), 16'(first_i), 16'(last_i)));

endmodule

// File: rtl/rxr_hdr_chain.sv
module rxr_hdr_chain #(
  parameter int WW = 14,
  parameter int N  = 4
) (
  input  logic [WW-1:0]       base_i,
  input  logic [WW-1:0]       first_i,
  input  logic [WW-1:0]       last_i,
  output logic [N:0][WW-1:0]  chain_o
);

  assign chain_o[0] = base_i;

  for (genvar k = 1; k <= N; k++) begin : g_link
    rxr_step #(.WW(WW)) u_step (
      .cur_i  (chain_o[k-1]),
      .first_i(first_i),
      .last_i (last_i),
      .nxt_o  (chain_o[k])
    );
  end

endmodule

// File: rtl/rxr_stop_reg.sv
module rxr_stop_reg #(
  parameter int AW = 15,
  localparam int PG_W = AW - 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PG_W-1:0] hi_page,
  input  logic          we,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] stop_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)  stop_q <= {hi_page, 8'hFE};
    else if (we) stop_q <= wdata;
  end

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int AW = 15,
  localparam int WW   = AW - 1,
  localparam int PG_W = AW - 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [7:0]      in_byte,
  input  logic            in_last,
  input  logic            in_err,
  output logic            in_ready,
  input  logic [PG_W-1:0] lim_lo,
  input  logic [PG_W-1:0] lim_hi,
  input  logic            stop_we,
  input  logic [AW-1:0]   stop_wdata,
  output logic            mem_we,
  output logic [WW-1:0]   mem_waddr,
  output logic [15:0]     mem_wdata,
  output logic [AW-1:0]   wr_base,
  output logic            frame_done,
  output logic            overrun
);
  import rxr_pkg::*;

  wr_state_t st;
  logic [WW-1:0] base_w, cur_w, next_w;
  logic [WW-1:0] first_w, last_w, stop_w;
  logic [WW-1:0] wt, wt_nx;
  logic [AW-1:0] stop_q;
  logic [HDR_WORDS:0][WW-1:0] hchain;
  logic [7:0] lo_byte;
  logic       have_lo, err_q;
  logic [CNT_BITS-1:0] len_q;
  logic [15:0] gap;
  logic [15:0] word_d;

  // named internal events
  logic is_idle, is_recv, ev_accept, ev_block, pair, flush, hit_stop;

  assign first_w = {lim_lo, {PAGE_LOG{1'b0}}};
  assign last_w  = {lim_hi, {PAGE_LOG{1'b1}}};
  assign stop_w  = WW'(stop_q >> 1);
  assign wr_base = {base_w, 1'b0};

  rxr_stop_reg #(.AW(AW)) u_stop (
    .clk(clk), .rst_n(rst_n), .hi_page(lim_hi),
    .we(stop_we), .wdata(stop_wdata), .stop_q(stop_q)
  );

  rxr_hdr_chain #(.WW(WW), .N(HDR_WORDS)) u_chain (
    .base_i(base_w), .first_i(first_w), .last_i(last_w), .chain_o(hchain)
  );

  assign is_idle  = (st == S_IDLE);
  assign is_recv  = (st == S_RECV);
  assign in_ready = is_idle | is_recv | (st == S_DROP);
  assign ev_accept = in_valid & in_ready;

  assign gap      = ring_gap(16'(base_w), 16'(stop_w), 16'(first_w), 16'(last_w));
  assign ev_block = is_idle & (gap < 16'(HDR_WORDS));

  // target of the next payload word
  assign wt = is_idle ? hchain[HDR_WORDS] : cur_w;

  rxr_step #(.WW(WW)) u_wt (
    .cur_i(wt), .first_i(first_w), .last_i(last_w), .nxt_o(wt_nx)
  );

  assign pair     = is_recv & have_lo;
  assign flush    = pair | in_last;
  assign word_d   = pair ? {in_byte, lo_byte} : {8'h00, in_byte};
  assign hit_stop = (wt == stop_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_CLR;
      base_w     <= first_w;
      cur_w      <= '0;
      next_w     <= '0;
      lo_byte    <= '0;
      have_lo    <= 1'b0;
      err_q      <= 1'b0;
      len_q      <= '0;
      mem_we     <= 1'b0;
      mem_waddr  <= '0;
      mem_wdata  <= '0;
      frame_done <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      mem_we     <= 1'b0;
      frame_done <= 1'b0;
      overrun    <= 1'b0;
      case (st)
        S_CLR: begin
          mem_we    <= 1'b1;
          mem_waddr <= hchain[0];
          mem_wdata <= EVT_PEND;
          st        <= S_IDLE;
        end
        S_IDLE, S_RECV: begin
          if (ev_accept) begin
            if (ev_block) begin
              overrun <= 1'b1;
              st      <= in_last ? S_IDLE : S_DROP;
            end else begin
              len_q <= is_idle ? CNT_BITS'(1) : len_q + CNT_BITS'(1);
              err_q <= (is_idle ? 1'b0 : err_q) | in_err;
              if (flush) begin
                have_lo <= 1'b0;
                if (hit_stop) begin
                  overrun <= 1'b1;
                  st      <= in_last ? S_IDLE : S_DROP;
                end else begin
                  mem_we    <= 1'b1;
                  mem_waddr <= wt;
                  mem_wdata <= word_d;
                  cur_w     <= wt_nx;
                  if (in_last) begin
                    next_w <= wt_nx;
                    st     <= S_HST;
                  end else begin
                    st <= S_RECV;
                  end
                end
              end else begin
                lo_byte <= in_byte;
                have_lo <= 1'b1;
                cur_w   <= wt;
                st      <= S_RECV;
              end
            end
          end
        end
        S_DROP: begin
          if (ev_accept && in_last) st <= S_IDLE;
        end
        S_HST: begin
          mem_we    <= 1'b1;
          mem_waddr <= hchain[1];
          mem_wdata <= err_q ? ST_BAD : ST_GOOD;
          st        <= S_HNX;
        end
        S_HNX: begin
          mem_we    <= 1'b1;
          mem_waddr <= hchain[2];
          mem_wdata <= 16'({next_w, 1'b0});
          st        <= S_HCT;
        end
        S_HCT: begin
          mem_we    <= 1'b1;
          mem_waddr <= hchain[3];
          mem_wdata <= 16'(len_q);
          st        <= S_HEV;
        end
        S_HEV: begin
          mem_we     <= 1'b1;
          mem_waddr  <= hchain[0];
          mem_wdata  <= EVT_DONE;
          base_w     <= next_w;
          frame_done <= 1'b1;
          st         <= S_CLR;
        end
        default: st <= S_CLR;
      endcase
    end
  end

endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter int AW = 15,
  localparam int WW   = AW - 1,
  localparam int PG_W = AW - 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_we,
  input logic [WW-1:0]   mem_waddr,
  input logic [15:0]     mem_wdata,
  input logic            frame_done,
  input logic            overrun,
  input logic            in_ready,
  input logic [AW-1:0]   wr_base,
  input logic [PG_W-1:0] lim_lo,
  input logic [PG_W-1:0] lim_hi,
  input logic [WW-1:0]   stop_w
);

  // R9
  stop_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !$past(frame_done)) |-> (mem_waddr != $past(stop_w)));

  // R9
  drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && overrun));

  // R7
  in_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_waddr >= {lim_lo, 7'h00} && mem_waddr <= {lim_hi, 7'h7F}));

  // R3
  event_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (mem_we && mem_wdata == 16'h0008 &&
                    mem_waddr == $past(wr_base[AW-1:1])));

  // R11
  clear_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (mem_we && mem_wdata == 16'h0000 &&
                    mem_waddr == wr_base[AW-1:1]));

  // R10
  busy_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !in_ready);

  // R6
  base_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_base != $past(wr_base)) |-> frame_done);

endmodule

bind rx_ring_writer rx_ring_writer_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_waddr(mem_waddr),
  .mem_wdata(mem_wdata), .frame_done(frame_done), .overrun(overrun),
  .in_ready(in_ready), .wr_base(wr_base), .lim_lo(lim_lo), .lim_hi(lim_hi),
  .stop_w(stop_w)
);

// File: tb/rx_ring_writer_tb_top.sv
`timescale 1ns/1ps
module rx_ring_writer_tb_top;
  localparam int AW = 11;
  localparam int LO_PG = 1;
  localparam int HI_PG = 3;
  localparam int LO_B  = LO_PG * 256;
  localparam int TOP_B = HI_PG * 256 + 254;
  localparam int SIZE_W = (HI_PG - LO_PG + 1) * 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, in_err = 1'b0, in_ready;
  logic [7:0] in_byte = '0;
  logic stop_we = 1'b0;
  logic [AW-1:0] stop_wdata = '0;
  logic mem_we, frame_done, overrun;
  logic [AW-2:0] mem_waddr;
  logic [15:0] mem_wdata;
  logic [AW-1:0] wr_base;

  always #2 clk = ~clk;

  rx_ring_writer #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_last(in_last), .in_err(in_err), .in_ready(in_ready),
    .lim_lo(3'(LO_PG)), .lim_hi(3'(HI_PG)), .stop_we(stop_we),
    .stop_wdata(stop_wdata), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .wr_base(wr_base), .frame_done(frame_done),
    .overrun(overrun)
  );

  logic [15:0] mem [1024];
  int n_chk = 0, n_fail = 0, n_done = 0, n_ovr = 0;
  int exp_base = LO_B;
  int stop_b = TOP_B;

  always @(negedge clk) begin
    if (mem_we) mem[mem_waddr] = mem_wdata;
    if (rst_n && frame_done) n_done++;
    if (rst_n && overrun) n_ovr++;
  end

  function automatic int nb(int a);
    return (a == TOP_B) ? LO_B : a + 2;
  endfunction

  function automatic logic [7:0] pat(int seed, int i);
    return 8'(seed * 37 + i * 11 + (i >> 2));
  endfunction

  function automatic int host_stop(int nextb);
    return (nextb == LO_B) ? TOP_B : nextb - 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_stop(input int v);
    @(negedge clk);
    stop_we = 1'b1;
    stop_wdata = AW'(v);
    @(negedge clk);
    stop_we = 1'b0;
    stop_b = v;
  endtask

  task automatic send_frame(input int len, input int seed, input bit bad,
                            output int low_cycles);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = pat(seed, i);
      in_last  = (i == len - 1);
      in_err   = bad && (i == len - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
    low_cycles = 0;
    while (!in_ready && low_cycles < 20) begin
      low_cycles++;
      @(negedge clk);
    end
  endtask

  task automatic do_frame(input int len, input int seed, input bit bad, input bit consume);
    int gap, nwords, d0, o0, lowc, a, p, bad_words, nextb;
    bit ok;
    logic [15:0] w;
    nwords = (len + 1) / 2;
    gap = ((stop_b >> 1) - (exp_base >> 1) + SIZE_W) % SIZE_W;
    ok = (gap >= 4 + nwords);
    d0 = n_done; o0 = n_ovr;
    send_frame(len, seed, bad, lowc);
    repeat (3) @(negedge clk);
    if (ok) begin
      a = exp_base;
      p = nb(nb(nb(nb(a))));
      bad_words = 0;
      for (int j = 0; j < nwords; j++) begin
        w[7:0]  = pat(seed, 2 * j);
        w[15:8] = (2 * j + 1 < len) ? pat(seed, 2 * j + 1) : 8'h00;
        if (mem[p >> 1] !== w) bad_words++;
        p = nb(p);
      end
      nextb = p;
      chk(n_done == d0 + 1 && n_ovr == o0, "R9 stored frame, no overrun", n_done - d0, 1);
      chk(mem[a >> 1] == 16'h0008, "R3 event word", mem[a >> 1], 16'h0008);
      chk(mem[nb(a) >> 1] == (bad ? 16'h0001 : 16'h2000), "R4 status word",
          mem[nb(a) >> 1], bad ? 16'h0001 : 16'h2000);
      chk(mem[nb(nb(a)) >> 1] == 16'(nextb), "R6 next field", mem[nb(nb(a)) >> 1], nextb);
      chk(mem[nb(nb(nb(a))) >> 1] == 16'(len & 16'h3FFF), "R5 count word",
          mem[nb(nb(nb(a))) >> 1], len);
      chk(bad_words == 0, "R2/R7 payload words", bad_words, 0);
      chk(int'(wr_base) == nextb, "R6 wr_base", wr_base, nextb);
      chk(mem[nextb >> 1] == 16'h0000, "R11 next event cleared", mem[nextb >> 1], 0);
      chk(lowc == 5, "R10 ready low cycles", lowc, 5);
      exp_base = nextb;
      if (consume) set_stop(host_stop(nextb));
    end else begin
      chk(n_ovr == o0 + 1 && n_done == d0, "R9 dropped frame pulses", n_ovr - o0, 1);
      chk(int'(wr_base) == exp_base, "R9 base kept", wr_base, exp_base);
      chk(mem[exp_base >> 1] == 16'h0000, "R9 base not ready", mem[exp_base >> 1], 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'hDEAD;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1 state right after reset
    chk(int'(wr_base) == LO_B, "R1 wr_base at reset", wr_base, LO_B);
    chk(!overrun && !frame_done, "R1 pulses low", {overrun, frame_done}, 0);
    chk(!in_ready, "R1 not ready before clear", in_ready, 0);
    repeat (3) @(negedge clk);
    chk(mem[LO_B >> 1] == 16'h0000, "R1 base event cleared", mem[LO_B >> 1], 0);
    chk(in_ready, "R1 ready after clear", in_ready, 1);

    // sweep lengths, host consumes each record
    for (int len = 1; len <= 40; len++)
      do_frame(len, len, (len % 7) == 3, 1'b1);

    // fill without consuming until drops
    for (int k = 0; k < 13; k++) do_frame(60, 100 + k, 1'b0, 1'b0);
    set_stop(host_stop(exp_base));
    do_frame(10, 200, 1'b0, 1'b1);

    // header and first-word boundaries
    set_stop(nb(nb(exp_base)));
    do_frame(3, 210, 1'b0, 1'b0);
    set_stop(nb(nb(nb(nb(exp_base)))));
    do_frame(1, 211, 1'b0, 1'b0);
    set_stop(nb(nb(nb(nb(nb(exp_base))))));
    do_frame(2, 212, 1'b1, 1'b0);

    // R8 stop reset value: exact fill from reset
    for (int t = 0; t < 2; t++) begin
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      mem[LO_B >> 1] = 16'hDEAD;
      rst_n = 1'b1;
      exp_base = LO_B;
      stop_b = TOP_B;
      repeat (3) @(negedge clk);
      do_frame(758 + t, 300 + t, 1'b0, 1'b0);
      chk(n_chk > 0, t == 0 ? "R8 full ring accepted" : "R8 one over dropped", t, t);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule